// File: doc/BRIEF.md
# Shadowed Capture Descriptor Client

This block sits between a list manager and a video capture input. The list manager hands it frame descriptors. Each descriptor carries a destination identifier and a flag that turns on split-line multiplexed mode. The block keeps one descriptor in a shadow slot while the current frame runs on an active copy. The list manager can therefore queue the next frame's descriptor without waiting for the frame in flight to end.

On every vertical sync the shadow descriptor is promoted to active, and the shadow slot empties. If the shadow slot is empty when the sync arrives, the frame that follows has no descriptor. In that case a one-cycle drop pulse is raised, a saturating drop counter advances, and every line of that frame is discarded.

Accepted lines are forwarded one cycle later with the active destination and their channel number. In split-line mode, bit 0 of the channel separates split lines from complete lines, and each kind leaves on its own valid strobe. This keeps a channel that stops partway through a line from mixing its data into the complete-line stream.

Top module: `shadow_capture_client`

## Requirements
- R1: After reset, descReady is 1, dropCount is 0, and frameDrop, outCompleteValid and outSplitValid are 0.
- R2: A descriptor offered while descReady is 1 is taken into the shadow slot, and descReady is 0 from the next cycle. A descriptor offered while descReady is 0 is discarded, so the destination used after the next sync is the one stored first.
- R3: A sync while the shadow slot is full makes the shadow descriptor active and sets descReady to 1 in the next cycle. No drop pulse is raised.
- R4: A sync while the shadow slot is empty raises frameDrop for exactly the one cycle after the sync. No line is forwarded until a later sync promotes a descriptor; this also applies to lines before the first sync.
- R5: dropCount rises by one for each dropped frame and holds at its maximum value (all ones) once it gets there. It changes only together with a frameDrop pulse.
- R6: A line marker received while a descriptor is active produces, one cycle later, a single output strobe with outDest equal to the active destination and outChan equal to the input channel.
- R7: With split mode on in the active descriptor, channel bit 0 equal to 1 drives outSplitValid and bit 0 equal to 0 drives outCompleteValid. With split mode off, every line drives outCompleteValid. The two strobes are never high together.
- R8: A descriptor loaded during a running frame does not change the destination or routing of that frame's lines.
- R9: A line marker in the same cycle as a sync is not forwarded.
- R10: A descriptor offered in the same cycle as a sync that finds the shadow slot empty is stored. That frame is still dropped, and the descriptor becomes active at the following sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Descriptor offered by the list manager |
| descDest | input | DEST_W | Destination identifier of the offered descriptor |
| descSplit | input | 1 | Split-line multiplexed mode flag of the offered descriptor |
| descReady | output | 1 | Shadow slot empty, descriptor can be taken |
| vidVsync | input | 1 | Vertical sync, one-cycle pulse |
| vidLine | input | 1 | Line marker, one cycle per line |
| vidChan | input | CHAN_W | Channel number of the line |
| outCompleteValid | output | 1 | Forwarded complete line |
| outSplitValid | output | 1 | Forwarded split line |
| outDest | output | DEST_W | Destination tag of the forwarded line |
| outChan | output | CHAN_W | Channel of the forwarded line |
| frameDrop | output | 1 | One-cycle pulse for a frame dropped for lack of a descriptor |
| dropCount | output | CNT_W | Saturating count of dropped frames |

## Verification
A shadow-full flag that is wrong shows up in the cycle after the next load or sync. It appears either as descReady at the wrong level or as a drop pulse that should not be there. A corrupted active descriptor only becomes visible on the first line of the frame it governs, one cycle after that line, through outDest or through the strobe that fires. The bench therefore sweeps every channel value in both modes after each promotion. It also checks descReady, frameDrop and dropCount in the cycle straight after each sync.

// File: rtl/shadow_capture_pkg.sv
package shadow_capture_pkg;
  typedef struct packed {
    logic loadShadow;
    logic promote;
    logic dropFrame;
    logic acceptLine;
  } ctrlStrobeT;
endpackage

// File: rtl/shadow_capture_ctrl.sv
module shadow_capture_ctrl
  import shadow_capture_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descValid,
  input  logic       vidVsync,
  input  logic       vidLine,
  output logic       descReady,
  output ctrlStrobeT strobe
);
  logic shadowFull;
  logic activeValid;

  assign descReady = ~shadowFull;

  always_comb begin
    strobe.loadShadow = descValid & ~shadowFull;
    strobe.promote    = vidVsync & shadowFull;
    strobe.dropFrame  = vidVsync & ~shadowFull;
    strobe.acceptLine = vidLine & activeValid & ~vidVsync;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowFull  <= 1'b0;
      activeValid <= 1'b0;
    end else begin
      // a promote empties the slot; a load can only happen while it is empty
      if (strobe.promote)         shadowFull <= 1'b0;
      else if (strobe.loadShadow) shadowFull <= 1'b1;
      if (strobe.promote)         activeValid <= 1'b1;
      else if (strobe.dropFrame)  activeValid <= 1'b0;
    end
  end
endmodule

// File: rtl/shadow_capture_data.sv
module shadow_capture_data
  import shadow_capture_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int CHAN_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [DEST_W-1:0] descDest,
  input  logic              descSplit,
  input  logic [CHAN_W-1:0] vidChan,
  output logic              outCompleteValid,
  output logic              outSplitValid,
  output logic [DEST_W-1:0] outDest,
  output logic [CHAN_W-1:0] outChan,
  output logic              frameDrop,
  output logic [CNT_W-1:0]  dropCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DEST_W-1:0] shadowDest, activeDest;
  logic              shadowSplit, activeSplit;
  logic              lineIsSplit;

  assign lineIsSplit = activeSplit & vidChan[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowDest  <= '0;
      shadowSplit <= 1'b0;
      activeDest  <= '0;
      activeSplit <= 1'b0;
    end else begin
      if (strobe.loadShadow) begin
        shadowDest  <= descDest;
        shadowSplit <= descSplit;
      end
      if (strobe.promote) begin
        activeDest  <= shadowDest;
        activeSplit <= shadowSplit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCompleteValid <= 1'b0;
      outSplitValid    <= 1'b0;
      outDest          <= '0;
      outChan          <= '0;
    end else begin
      outCompleteValid <= strobe.acceptLine & ~lineIsSplit;
      outSplitValid    <= strobe.acceptLine & lineIsSplit;
      if (strobe.acceptLine) begin
        outDest <= activeDest;
        outChan <= vidChan;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameDrop <= 1'b0;
      dropCount <= '0;
    end else begin
      frameDrop <= strobe.dropFrame;
      if (strobe.dropFrame && dropCount != CNT_MAX) dropCount <= dropCount + 1'b1;
    end
  end
endmodule

// File: rtl/shadow_capture_client.sv
module shadow_capture_client
  import shadow_capture_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int CHAN_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descValid,
  input  logic [DEST_W-1:0] descDest,
  input  logic              descSplit,
  output logic              descReady,
  input  logic              vidVsync,
  input  logic              vidLine,
  input  logic [CHAN_W-1:0] vidChan,
  output logic              outCompleteValid,
  output logic              outSplitValid,
  output logic [DEST_W-1:0] outDest,
  output logic [CHAN_W-1:0] outChan,
  output logic              frameDrop,
  output logic [CNT_W-1:0]  dropCount
);
  ctrlStrobeT strobe;

  shadow_capture_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .descValid(descValid),
    .vidVsync (vidVsync),
    .vidLine  (vidLine),
    .descReady(descReady),
    .strobe   (strobe)
  );

  shadow_capture_data #(.DEST_W(DEST_W), .CHAN_W(CHAN_W), .CNT_W(CNT_W)) u_data (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .descDest        (descDest),
    .descSplit       (descSplit),
    .vidChan         (vidChan),
    .outCompleteValid(outCompleteValid),
    .outSplitValid   (outSplitValid),
    .outDest         (outDest),
    .outChan         (outChan),
    .frameDrop       (frameDrop),
    .dropCount       (dropCount)
  );
endmodule

// File: rtl/shadow_capture_chk.sv
module shadow_capture_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             descValid,
  input logic             descReady,
  input logic             vidVsync,
  input logic             outCompleteValid,
  input logic             outSplitValid,
  input logic             frameDrop,
  input logic [CNT_W-1:0] dropCount
);
  assert_load_fills_R2: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady) |=> !descReady);

  assert_promote_no_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (vidVsync && !descReady) |=> (descReady && !frameDrop));

  assert_empty_sync_drops_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vidVsync && descReady) |=> frameDrop);

  assert_drop_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameDrop |=> !frameDrop);

  assert_count_moves_with_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> frameDrop);

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(outCompleteValid && outSplitValid));

  assert_sync_line_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    vidVsync |=> !(outCompleteValid || outSplitValid));
endmodule

bind shadow_capture_client shadow_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .descValid       (descValid),
  .descReady       (descReady),
  .vidVsync        (vidVsync),
  .outCompleteValid(outCompleteValid),
  .outSplitValid   (outSplitValid),
  .frameDrop       (frameDrop),
  .dropCount       (dropCount)
);

// File: tb/shadow_capture_client_tb.sv
module shadow_capture_client_tb;
  localparam int DEST_W = 4;
  localparam int CHAN_W = 4;
  localparam int CNT_W  = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic descValid = 1'b0;
  logic [DEST_W-1:0] descDest = '0;
  logic descSplit = 1'b0;
  logic descReady;
  logic vidVsync = 1'b0;
  logic vidLine = 1'b0;
  logic [CHAN_W-1:0] vidChan = '0;
  logic outCompleteValid, outSplitValid;
  logic [DEST_W-1:0] outDest;
  logic [CHAN_W-1:0] outChan;
  logic frameDrop;
  logic [CNT_W-1:0] dropCount;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shadow_capture_client #(.DEST_W(DEST_W), .CHAN_W(CHAN_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .descValid(descValid), .descDest(descDest), .descSplit(descSplit), .descReady(descReady),
    .vidVsync(vidVsync), .vidLine(vidLine), .vidChan(vidChan),
    .outCompleteValid(outCompleteValid), .outSplitValid(outSplitValid),
    .outDest(outDest), .outChan(outChan),
    .frameDrop(frameDrop), .dropCount(dropCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives one cycle of inputs 1 ns after an edge, then waits past the next edge
  task automatic drive(input logic vs, input logic ln, input int ch,
                       input logic dv, input int dd, input logic ds);
    vidVsync  = vs;
    vidLine   = ln;
    vidChan   = ch[CHAN_W-1:0];
    descValid = dv;
    descDest  = dd[DEST_W-1:0];
    descSplit = ds;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic noLine(input string req);
    check(req, int'(outCompleteValid) + int'(outSplitValid), 0);
  endtask

  task automatic dropSync(input string req);
    drive(1, 0, 0, 0, 0, 0);
    expCount = (expCount < CNT_MAX) ? expCount + 1 : CNT_MAX;
    check(req, int'(frameDrop), 1);
    check("R5 count", int'(dropCount), expCount);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 descReady", int'(descReady), 1);
    check("R1 dropCount", int'(dropCount), 0);
    check("R1 frameDrop", int'(frameDrop), 0);
    noLine("R1 outputs");
    rstN = 1'b1;
    idle();

    // R4 no descriptor yet: line dropped
    drive(0, 1, 2, 0, 0, 0);
    noLine("R4 line before first sync");

    // R4 R5 sync with empty shadow
    dropSync("R4 drop pulse");
    idle();
    check("R4 pulse one cycle", int'(frameDrop), 0);
    drive(0, 1, 3, 0, 0, 0);
    noLine("R4 line in dropped frame");

    // R2 load then refused load
    drive(0, 0, 0, 1, 5, 0);
    check("R2 ready low after load", int'(descReady), 0);
    drive(0, 0, 0, 1, 9, 1);
    check("R2 ready stays low", int'(descReady), 0);

    // R3 promote
    drive(1, 0, 0, 0, 0, 0);
    check("R3 no drop", int'(frameDrop), 0);
    check("R3 ready high", int'(descReady), 1);
    check("R3 count held", int'(dropCount), expCount);

    // R6 R7 sweep, split mode off, dest 5 (R2: refused dest 9 not used)
    for (int c = 0; c < (1 << CHAN_W); c++) begin
      drive(0, 1, c, 0, 0, 0);
      check("R7 complete", int'(outCompleteValid), 1);
      check("R7 split", int'(outSplitValid), 0);
      check("R2 R6 dest", int'(outDest), 5);
      check("R6 chan", int'(outChan), c);
    end
    idle();
    noLine("R6 single strobe");

    // R8 load during running frame
    drive(0, 1, 7, 1, 3, 1);
    check("R8 dest unchanged", int'(outDest), 5);
    check("R8 routing unchanged", int'(outCompleteValid), 1);
    check("R8 ready low", int'(descReady), 0);

    // R9 line with sync
    drive(1, 1, 5, 0, 0, 0);
    noLine("R9 line on sync");
    check("R3 ready after promote", int'(descReady), 1);

    // R7 sweep, split mode on, dest 3
    for (int c = 0; c < (1 << CHAN_W); c++) begin
      drive(0, 1, c, 0, 0, 0);
      check("R7 split strobe", int'(outSplitValid), c & 1);
      check("R7 complete strobe", int'(outCompleteValid), 1 - (c & 1));
      check("R6 dest split frame", int'(outDest), 3);
      check("R6 chan split frame", int'(outChan), c);
    end

    // R10 load coincident with sync on empty shadow
    drive(1, 0, 0, 1, 10, 0);
    expCount = (expCount < CNT_MAX) ? expCount + 1 : CNT_MAX;
    check("R10 drop", int'(frameDrop), 1);
    check("R10 stored", int'(descReady), 0);
    check("R5 count R10", int'(dropCount), expCount);
    drive(0, 1, 1, 0, 0, 0);
    noLine("R10 dropped frame line");
    drive(1, 0, 0, 0, 0, 0);
    check("R10 promote no drop", int'(frameDrop), 0);
    drive(0, 1, 1, 0, 0, 0);
    check("R10 dest", int'(outDest), 10);
    check("R10 complete", int'(outCompleteValid), 1);

    // R5 saturation
    for (int i = 0; i < CNT_MAX + 2; i++) begin
      dropSync("R5 drop");
      idle();
    end
    check("R5 saturated", int'(dropCount), CNT_MAX);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule